// File: doc/BRIEF.md
# DRAM Bank Open-Row Access Sequencer

This block models a single DRAM bank that holds one open row in a row buffer. A requester hands it one read or write at a time over a valid/ready channel. Each request carries a row address, a column address that picks an 8-bit slot inside the row, and write data. On acceptance the block compares the row against the open row. The result is a hit (same row open), empty (no row open) or conflict (another row open). It then steps through the command sequence that this class needs. A conflict writes the open row back to the array, activates the new row, then does the column access. An empty buffer needs an activate and a column access. A hit needs only the column access.

Read data leaves on a single serial pin, one bit per cycle, least significant bit first. A done pulse marks the last of the eight transfer cycles. The wait before the first bit depends on the class: 2, 4 or 6 cycles by default, keeping the 1:2:3 ratio of the bank's nominal hit, empty and conflict access times. A write on an open row changes only the row buffer. The array copy catches up when that row is written back on a later conflict. A status output gives the class of the request in flight, so a model of the open row can be checked against it. The defaults use a small bank (16 rows of 64 bits). Setting the row and column widths to 12 gives the full 4096 x 4096 organisation.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, reqReady is 1, respValid, respDone and respBit are 0, respClass is 0 (none), cmd is 0 (no-op), and no row is open, so the first request is classed as empty.
- R2: At acceptance (reqValid and reqReady high at a rising edge) the request is classed on respClass as 2 (empty) when no row is open, 1 (hit) when its row equals the open row, and 3 (conflict) otherwise. The value holds until the next acceptance.
- R3: Count the acceptance edge as edge 0. The first transfer cycle follows edge L, where L is LAT_HIT, LAT_EMPTY or LAT_CONF for hit, empty or conflict.
- R4: In wait cycle w (the cycle after edge w, 0 <= w < L), cmd shows 1 (precharge with writeback) at w=0 for a conflict only. It shows 2 (activate) at w=L-LAT_EMPTY for empty and conflict. It shows 3 (column access) at w=L-1 for every class, and 0 in every other cycle.
- R5: A read returns eight bits on respBit, least significant bit first, in the eight cycles after edges L..L+7. respValid is high exactly in those cycles, and respDone is high only in the last one.
- R6: reqReady is low from the cycle after acceptance through the done cycle and high again in the following cycle. A request held valid during that time is not taken.
- R7: A write to the open row replaces the addressed slot in the row buffer. A later read hit to that slot returns the written byte, and the other slots keep their values.
- R8: A conflict first stores the whole open row buffer, including buffered writes, back to the array. Reopening that row later returns the written data.
- R9: Reset loads array row r, slot s with the byte (17*r + 3*s + 1) mod 256.
- R10: A write keeps the same wait and transfer timing as a read. respValid stays low, and respDone still pulses after edge L+7.
- R11: Column value c selects bits [8c+7:8c] of the row for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block is idle and takes a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Slot address within the row |
| reqWdata | input | BURST | Write byte |
| respValid | output | 1 | Read data bit valid |
| respBit | output | 1 | Serial read data, LSB first |
| respDone | output | 1 | Last transfer cycle of a request |
| respClass | output | 2 | Class of current request: 0 none, 1 hit, 2 empty, 3 conflict |
| cmd | output | 2 | Bank command this cycle: 0 nop, 1 precharge/writeback, 2 activate, 3 column |

## Verification
The bench builds a request chain from reset that passes through every class. It writes into open rows and then forces conflicts that must carry those writes back to the array. A missing writeback would bring back the reset pattern instead of the written byte. A wrong slot index would corrupt a neighbouring slot or read the wrong byte. A latency taken from the wrong class would move the first data bit and the done pulse away from the expected cycle. A request held valid while the bank is busy, and a reset in the middle of a conflict, show whether the block takes requests early or keeps a stale open row after reset.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;
  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_HIT      = 2'd1,
    CLS_EMPTY    = 2'd2,
    CLS_CONFLICT = 2'd3
  } accClassT;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_COL = 2'd3
  } bankCmdT;

  // control-to-datapath strobes
  typedef struct packed {
    logic accept;  // latch request fields
    logic preWb;   // write open row back, close it
    logic act;     // copy addressed row into buffer
    logic colRd;   // load serialiser from buffer slot
    logic colWr;   // store write byte into buffer slot
    logic shift;   // advance serialiser
  } bankStrobeT;
endpackage

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
  import dram_bank_pkg::*;
#(
  parameter int LAT_HIT   = 2,
  parameter int LAT_EMPTY = 4,
  parameter int LAT_CONF  = 6,
  parameter int BURST     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       rowOpen,
  input  logic       rowMatch,
  output logic       reqReady,
  output bankStrobeT strobe,
  output accClassT   curClass,
  output bankCmdT    cmd,
  output logic       respValid,
  output logic       respDone
);
  localparam int LAT_W = $clog2(LAT_CONF + 1);
  localparam int BIT_W = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [LAT_W-1:0] L_HIT   = LAT_W'(LAT_HIT);
  localparam logic [LAT_W-1:0] L_EMPTY = LAT_W'(LAT_EMPTY);
  localparam logic [LAT_W-1:0] L_CONF  = LAT_W'(LAT_CONF);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BURST - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} seqStateT;

  seqStateT         state;
  logic [LAT_W-1:0] waitCnt, lat;
  logic [BIT_W-1:0] bitCnt;
  logic             isWrite;
  accClassT         clsNext;
  logic [LAT_W-1:0] latNext;
  logic             colCycle;

  always_comb begin
    if (!rowOpen)      clsNext = CLS_EMPTY;
    else if (rowMatch) clsNext = CLS_HIT;
    else               clsNext = CLS_CONFLICT;
    case (clsNext)
      CLS_HIT:   latNext = L_HIT;
      CLS_EMPTY: latNext = L_EMPTY;
      default:   latNext = L_CONF;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign colCycle = (state == ST_WAIT) && (waitCnt == lat - LAT_W'(1));

  always_comb begin
    strobe        = '0;
    strobe.accept = reqReady && reqValid;
    strobe.preWb  = (state == ST_WAIT) && (waitCnt == '0) && (curClass == CLS_CONFLICT);
    strobe.act    = (state == ST_WAIT) && (curClass != CLS_HIT) && (waitCnt == lat - L_EMPTY);
    strobe.colRd  = colCycle && !isWrite;
    strobe.colWr  = colCycle && isWrite;
    strobe.shift  = (state == ST_XFER);
  end

  always_comb begin
    if (colCycle)          cmd = CMD_COL;
    else if (strobe.preWb) cmd = CMD_PRE;
    else if (strobe.act)   cmd = CMD_ACT;
    else                   cmd = CMD_NOP;
  end

  assign respValid = (state == ST_XFER) && !isWrite;
  assign respDone  = (state == ST_XFER) && (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      lat      <= '0;
      bitCnt   <= '0;
      isWrite  <= 1'b0;
      curClass <= CLS_NONE;
    end else begin
      case (state)
        ST_IDLE: if (strobe.accept) begin
          state    <= ST_WAIT;
          waitCnt  <= '0;
          lat      <= latNext;
          isWrite  <= reqWrite;
          curClass <= clsNext;
        end
        ST_WAIT: if (colCycle) begin
          state  <= ST_XFER;
          bitCnt <= '0;
        end else begin
          waitCnt <= waitCnt + LAT_W'(1);
        end
        ST_XFER: if (bitCnt == LAST_BIT) state <= ST_IDLE;
                 else bitCnt <= bitCnt + BIT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_bank_dp.sv
module dram_bank_dp
  import dram_bank_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  parameter int BURST = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobeT       strobe,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic [BURST-1:0] reqWdata,
  output logic             rowOpen,
  output logic             rowMatch,
  output logic             serBit
);
  localparam int NROWS   = 1 << ROW_W;
  localparam int SLOTS   = 1 << COL_W;
  localparam int ROW_LEN = SLOTS * BURST;

  logic [ROW_LEN-1:0] arrayMem [NROWS];
  logic [ROW_LEN-1:0] rowBuf;
  logic [ROW_W-1:0]   openRow, latRow;
  logic [COL_W-1:0]   latCol;
  logic [BURST-1:0]   latWdata, shiftReg;
  logic               openValid;

  function automatic logic [ROW_LEN-1:0] rowInit(input int r);
    logic [ROW_LEN-1:0] v;
    for (int s = 0; s < SLOTS; s++) v[s*BURST +: BURST] = BURST'(r * 17 + s * 3 + 1);
    return v;
  endfunction

  assign rowOpen  = openValid;
  assign rowMatch = (openRow == reqRow);
  assign serBit   = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NROWS; r++) arrayMem[r] <= rowInit(r);
      rowBuf    <= '0;
      openRow   <= '0;
      openValid <= 1'b0;
      latRow    <= '0;
      latCol    <= '0;
      latWdata  <= '0;
      shiftReg  <= '0;
    end else begin
      if (strobe.accept) begin
        latRow   <= reqRow;
        latCol   <= reqCol;
        latWdata <= reqWdata;
      end
      if (strobe.preWb) begin
        arrayMem[openRow] <= rowBuf;
        openValid         <= 1'b0;
      end
      if (strobe.act) begin
        rowBuf    <= arrayMem[latRow];
        openRow   <= latRow;
        openValid <= 1'b1;
      end
      if (strobe.colWr) rowBuf[int'(latCol)*BURST +: BURST] <= latWdata;
      if (strobe.colRd) shiftReg <= rowBuf[int'(latCol)*BURST +: BURST];
      else if (strobe.shift) shiftReg <= shiftReg >> 1;
    end
  end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_bank_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 3,
  parameter int BURST     = 8,
  parameter int LAT_HIT   = 2,
  parameter int LAT_EMPTY = 4,
  parameter int LAT_CONF  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic [BURST-1:0] reqWdata,
  output logic             respValid,
  output logic             respBit,
  output logic             respDone,
  output logic [1:0]       respClass,
  output logic [1:0]       cmd
);
  bankStrobeT strobe;
  accClassT   curClass;
  bankCmdT    cmdEnum;
  logic       rowOpen, rowMatch, serBit;

  dram_bank_ctrl #(
    .LAT_HIT(LAT_HIT), .LAT_EMPTY(LAT_EMPTY), .LAT_CONF(LAT_CONF), .BURST(BURST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rowOpen(rowOpen), .rowMatch(rowMatch), .reqReady(reqReady),
    .strobe(strobe), .curClass(curClass), .cmd(cmdEnum),
    .respValid(respValid), .respDone(respDone)
  );

  dram_bank_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BURST(BURST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .rowOpen(rowOpen), .rowMatch(rowMatch), .serBit(serBit)
  );

  assign respBit   = respValid & serBit;
  assign respClass = curClass;
  assign cmd       = cmdEnum;
endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk #(
  parameter int BURST     = 8,
  parameter int LAT_HIT   = 2,
  parameter int LAT_EMPTY = 4,
  parameter int LAT_CONF  = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       respValid,
  input logic       respDone,
  input logic [1:0] respClass,
  input logic [1:0] cmd
);
  logic [7:0] busyCnt;
  logic [7:0] expDone;

  always_ff @(posedge clk) begin
    if (!rstN)                      busyCnt <= '0;
    else if (reqValid && reqReady)  busyCnt <= '0;
    else if (!reqReady)             busyCnt <= busyCnt + 8'd1;
  end

  always_comb begin
    case (respClass)
      2'd1:    expDone = 8'(LAT_HIT + BURST - 1);
      2'd2:    expDone = 8'(LAT_EMPTY + BURST - 1);
      default: expDone = 8'(LAT_CONF + BURST - 1);
    endcase
  end

  p_busy_blocks_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);
  p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_done_reopens_r6: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> reqReady);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);
  p_pre_conflict_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd1) |-> (respClass == 2'd3));
  p_act_not_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd2) |-> (respClass == 2'd2 || respClass == 2'd3));
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> (busyCnt == expDone));
endmodule

bind dram_bank_seq dram_bank_seq_chk #(
  .BURST(BURST), .LAT_HIT(LAT_HIT), .LAT_EMPTY(LAT_EMPTY), .LAT_CONF(LAT_CONF)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respDone(respDone), .respClass(respClass), .cmd(cmd)
);

// File: tb/dram_bank_seq_bench.sv
`timescale 1ns/1ps
module dram_bank_seq_bench;
  localparam int LH = 2, LE = 4, LC = 6;

  typedef struct packed {
    logic       wr;
    logic [3:0] row;
    logic [2:0] col;
    logic [7:0] wdata;
    logic [1:0] cls;
    logic [7:0] data;
  } vecT;

  // from reset: pattern byte(r,s) = 17r + 3s + 1 (R9)
  localparam vecT VEC [12] = '{
    '{1'b0, 4'd2,  3'd1, 8'h00, 2'd2, 8'h26},  // empty read
    '{1'b0, 4'd2,  3'd5, 8'h00, 2'd1, 8'h32},  // hit, other slot
    '{1'b1, 4'd2,  3'd5, 8'hAA, 2'd1, 8'h00},  // write hit
    '{1'b0, 4'd2,  3'd5, 8'h00, 2'd1, 8'hAA},  // read back
    '{1'b0, 4'd7,  3'd0, 8'h00, 2'd3, 8'h78},  // conflict, writeback row 2
    '{1'b1, 4'd7,  3'd7, 8'h5C, 2'd1, 8'h00},  // write hit top slot
    '{1'b0, 4'd2,  3'd5, 8'h00, 2'd3, 8'hAA},  // reopen row 2
    '{1'b0, 4'd7,  3'd7, 8'h00, 2'd3, 8'h5C},  // reopen row 7
    '{1'b1, 4'd15, 3'd2, 8'hC3, 2'd3, 8'h00},  // write conflict
    '{1'b0, 4'd15, 3'd3, 8'h00, 2'd1, 8'h09},  // neighbour slot untouched
    '{1'b0, 4'd15, 3'd2, 8'h00, 2'd1, 8'hC3},
    '{1'b0, 4'd0,  3'd0, 8'h00, 2'd3, 8'h01}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0] reqRow = '0;
  logic [2:0] reqCol = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, respValid, respBit, respDone;
  logic [1:0] respClass, cmd;
  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dram_bank_seq u_dram_bank_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .respValid(respValid), .respBit(respBit), .respDone(respDone),
    .respClass(respClass), .cmd(cmd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int latOf(input logic [1:0] c);
    return (c == 2'd1) ? LH : (c == 2'd2) ? LE : LC;
  endfunction

  function automatic logic [1:0] expCmd(input logic [1:0] c, input int w);
    int l = latOf(c);
    if (w == l - 1) return 2'd3;
    if (c == 2'd3 && w == 0) return 2'd1;
    if (c != 2'd1 && w == l - LE) return 2'd2;
    return 2'd0;
  endfunction

  task automatic runReq(input vecT v, input int idx);
    int l = latOf(v.cls);
    int cmdBad = 0, readyBad = 0, validBad = 0, doneBad = 0, nBits = 0;
    logic [7:0] got = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = v.wr; reqRow = v.row; reqCol = v.col; reqWdata = v.wdata;
    @(posedge clk);
    #1 reqValid = 1'b0;
    for (int j = 0; j <= l + 8; j++) begin
      @(negedge clk);
      if (j == 0) chk(respClass == v.cls, $sformatf("R2 class req%0d", idx), respClass, v.cls);
      if (j < l && cmd != expCmd(v.cls, j)) cmdBad++;
      if (j >= l && cmd != 2'd0) cmdBad++;
      if ((j < l + 8) == reqReady) readyBad++;
      if (respValid != (!v.wr && j >= l && j < l + 8)) validBad++;
      if (respDone != (j == l + 7)) doneBad++;
      if (respValid && nBits < 8) begin got[nBits] = respBit; nBits++; end
    end
    chk(cmdBad == 0, $sformatf("R4 cmd sequence req%0d", idx), cmdBad, 0);
    chk(readyBad == 0, $sformatf("R6 ready window req%0d", idx), readyBad, 0);
    chk(validBad == 0, $sformatf("R3 R5 R10 valid window req%0d", idx), validBad, 0);
    chk(doneBad == 0, $sformatf("R3 R5 R10 done timing req%0d", idx), doneBad, 0);
    if (!v.wr)
      chk(got == v.data, $sformatf("R5 R7 R8 R9 R11 data req%0d", idx), got, v.data);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    chk(!respValid && !respDone && !respBit, "R1 resp idle after reset",
        {respValid, respDone, respBit}, 0);
    chk(respClass == 2'd0, "R1 class none after reset", respClass, 0);
    chk(cmd == 2'd0, "R1 cmd nop after reset", cmd, 0);

    for (int i = 0; i < 12; i++) runReq(VEC[i], i);

    // R6: request held valid while busy is not taken early (open row 0 -> hit)
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqRow = 4'd0; reqCol = 3'd1;
    @(posedge clk);
    begin
      int early = 0;
      for (int j = 0; j < LH + 8; j++) begin
        @(negedge clk);
        if (reqReady) early++;
      end
      chk(early == 0, "R6 held request blocked while busy", early, 0);
      @(negedge clk);
      chk(reqReady == 1'b1, "R6 ready after done", reqReady, 1);
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
    repeat (LH + 9) @(negedge clk);

    // R1: reset in the middle of a conflict access
    @(negedge clk);
    reqValid = 1'b1; reqRow = 4'd5; reqCol = 3'd0;
    @(posedge clk);
    #1 reqValid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && respClass == 2'd0 && cmd == 2'd0, "R1 state after mid reset",
        {reqReady, respClass, cmd}, 5'b10000);
    runReq('{1'b0, 4'd2, 3'd5, 8'h00, 2'd2, 8'h32}, 100);  // R1 R9 empty, array reloaded

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule